// File: doc/BRIEF.md
# Row-Hit-Aware DRAM Request Scheduler

This block holds a small queue of pending DRAM requests, each tagged with a rank, a bank and a row, and kept in the order they arrived. When asked to pick, it scans the whole queue in one cycle. It sorts the eligible entries into three classes and returns the oldest entry of the best class that is not empty. The winning entry then leaves the queue, and every younger entry moves up one place.

The block tracks the state of every bank: whether a row is open, which row that is, the earliest cycle at which a column command may issue, and how many column accesses the open row has had. The rest of the controller reports each command it sends through a small issue port, and the bank state follows those reports. A row closes by itself once it has had a configured number of column accesses.

The scheduler also takes a flag for each rank saying whether that rank can be used, the cycle at which the data bus becomes free, the current cycle, and a flag saying that the bus direction has just turned around.

Top module: `rowhit_sched`

## Requirements
- R1: After reset the queue is empty (`q_count` = 0), `sel_found` is 0 and every bank has no open row.
- R2: A request offered on `enq_valid` is appended behind the existing entries when fewer than DEPTH entries are queued. When the queue is full, the request is dropped and `q_count` stays at DEPTH.
- R3: The column threshold T is the larger of `cur_cycle` and (`bus_busy_until` + X − CAS_LAT). X is TURN_LAT when `dir_turn` is 1 and 0 otherwise. If `bus_busy_until` + X is below CAS_LAT, T is `cur_cycle`. A bank is ready when its column-allowed cycle is ≤ T.
- R4: An entry whose rank has its `rank_avail` bit (bit index = rank) at 0 is never selected, in any class.
- R5: An entry whose row equals the open row of its bank, with that bank ready, is a seamless hit. If any seamless hit exists, the oldest one wins.
- R6: An entry that misses the open row of its bank (or whose bank has no open row), with that bank ready, is a hidden-preparation candidate. When there is no seamless hit, the oldest such candidate wins.
- R7: An entry that hits the open row while its bank is not ready is a prepped candidate. It wins, oldest first, only when there is neither a seamless hit nor a hidden-preparation candidate.
- R8: When no entry qualifies, a select reports `sel_found` = 0 and the queue is left unchanged.
- R9: After a select strobe, `sel_found`, `sel_idx` and the winner's rank, bank and row are valid for one cycle. `sel_idx` is the winner's position counted from the head before removal. The winner is removed, and the younger entries keep their order.
- R10: `iss_cmd` encodes 1 = activate, 2 = column, 3 = precharge and 0 = none. Every command sets the bank's column-allowed cycle to `iss_col_at`. An activate opens `iss_row` and clears the access count. A precharge closes the bank. The MAX_COL-th column access closes the row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid | input | 1 | Append a request this cycle |
| enq_rank | input | RK_W | Rank of the new request |
| enq_bank | input | BK_W | Bank of the new request |
| enq_row | input | ROW_W | Row of the new request |
| rank_avail | input | RANKS | One bit per rank, 1 = usable |
| cur_cycle | input | CYC_W | Current cycle count |
| bus_busy_until | input | CYC_W | Cycle at which the data bus becomes free |
| dir_turn | input | 1 | The bus direction has just switched |
| sel_strobe | input | 1 | Pick and remove a winner |
| iss_cmd | input | 2 | Issued command: 0 none, 1 activate, 2 column, 3 precharge |
| iss_rank | input | RK_W | Rank of the issued command |
| iss_bank | input | BK_W | Bank of the issued command |
| iss_row | input | ROW_W | Row opened by an activate |
| iss_col_at | input | CYC_W | New column-allowed cycle for that bank |
| sel_found | output | 1 | A winner was found on the previous strobe |
| sel_idx | output | IDX_W | Position of the winner before removal |
| sel_rank | output | RK_W | Rank of the winner |
| sel_bank | output | BK_W | Bank of the winner |
| sel_row | output | ROW_W | Row of the winner |
| q_count | output | CNT_W | Number of queued entries |

## Verification
The hardest situation to reach is the one where the three classes compete inside a single queue. This needs several banks, each in a chosen state at the same moment: open on a given row, closed, ready, or not yet ready. It also needs the threshold inputs set so that some banks fall on each side of the ready line. The bench reaches this by resetting before each trial and using the issue port to put every bank into a random state. That state can be an open row, an open row that then has a few column accesses (sometimes enough to force it closed), or a row that is opened and then precharged. It then draws the bus and cycle values and the rank mask, fills the queue with requests aimed at a handful of rows, and drains the queue one select at a time. Short directed sequences fix the turnaround threshold, the rank masking and the forced closure, where a single cycle of difference changes the winner.

// File: rtl/rowhit_sched.sv
module rowhit_sched #(
  parameter int DEPTH    = 8,
  parameter int RANKS    = 2,
  parameter int BANKS    = 8,
  parameter int ROW_W    = 14,
  parameter int CYC_W    = 24,
  parameter int CAS_LAT  = 11,
  parameter int TURN_LAT = 2,
  parameter int MAX_COL  = 16,
  localparam int RK_W  = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BK_W  = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  input  logic [RK_W-1:0]  enq_rank,
  input  logic [BK_W-1:0]  enq_bank,
  input  logic [ROW_W-1:0] enq_row,
  input  logic [RANKS-1:0] rank_avail,
  input  logic [CYC_W-1:0] cur_cycle,
  input  logic [CYC_W-1:0] bus_busy_until,
  input  logic             dir_turn,
  input  logic             sel_strobe,
  input  logic [1:0]       iss_cmd,
  input  logic [RK_W-1:0]  iss_rank,
  input  logic [BK_W-1:0]  iss_bank,
  input  logic [ROW_W-1:0] iss_row,
  input  logic [CYC_W-1:0] iss_col_at,
  output logic             sel_found,
  output logic [IDX_W-1:0] sel_idx,
  output logic [RK_W-1:0]  sel_rank,
  output logic [BK_W-1:0]  sel_bank,
  output logic [ROW_W-1:0] sel_row,
  output logic [CNT_W-1:0] q_count
);
  localparam int NB   = RANKS * BANKS;
  localparam int NB_W = (NB > 1) ? $clog2(NB) : 1;
  localparam int EW   = CYC_W + 1;
  localparam int CC_W = $clog2(MAX_COL + 1);
  localparam logic [1:0] CMD_ACT = 2'd1;
  localparam logic [1:0] CMD_COL = 2'd2;
  localparam logic [1:0] CMD_PRE = 2'd3;

  logic [RK_W-1:0]  q_rank [DEPTH];
  logic [BK_W-1:0]  q_bank [DEPTH];
  logic [ROW_W-1:0] q_row  [DEPTH];
  logic [RK_W-1:0]  nx_rank [DEPTH];
  logic [BK_W-1:0]  nx_bank [DEPTH];
  logic [ROW_W-1:0] nx_row  [DEPTH];
  logic [CNT_W-1:0] cnt;

  logic             b_open [NB];
  logic [ROW_W-1:0] b_row  [NB];
  logic [CYC_W-1:0] b_at   [NB];
  logic [CC_W-1:0]  b_cc   [NB];

  logic [EW-1:0] t_end, t_base, min_col;
  assign t_end   = EW'(bus_busy_until) + (dir_turn ? EW'(TURN_LAT) : EW'(0));
  assign t_base  = t_end - EW'(CAS_LAT);
  assign min_col = (t_end < EW'(CAS_LAT) || t_base < EW'(cur_cycle)) ? EW'(cur_cycle) : t_base;

  logic found_s, found_h, found_p;
  logic [IDX_W-1:0] idx_s, idx_h, idx_p;

  always_comb begin
    logic [NB_W-1:0] bi;
    logic hit, rdy;
    found_s = 1'b0; found_h = 1'b0; found_p = 1'b0;
    idx_s = '0; idx_h = '0; idx_p = '0;
    for (int i = 0; i < DEPTH; i++) begin
      bi  = NB_W'(q_rank[i]) * NB_W'(BANKS) + NB_W'(q_bank[i]);
      hit = b_open[bi] && (b_row[bi] == q_row[i]);
      rdy = EW'(b_at[bi]) <= min_col;
      if (CNT_W'(i) < cnt && rank_avail[q_rank[i]]) begin
        if (hit && rdy && !found_s) begin found_s = 1'b1; idx_s = IDX_W'(i); end
        if (!hit && rdy && !found_h) begin found_h = 1'b1; idx_h = IDX_W'(i); end
        if (hit && !rdy && !found_p) begin found_p = 1'b1; idx_p = IDX_W'(i); end
      end
    end
  end

  logic             win_any, remove, enq_acc;
  logic [IDX_W-1:0] win_idx;
  logic [CNT_W-1:0] ins_pos;
  assign win_any = found_s | found_h | found_p;
  assign win_idx = found_s ? idx_s : (found_h ? idx_h : idx_p);
  assign remove  = sel_strobe && win_any;
  assign enq_acc = enq_valid && (cnt < CNT_W'(DEPTH));
  assign ins_pos = cnt - CNT_W'(remove);
  assign q_count = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt - CNT_W'(remove) + CNT_W'(enq_acc);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    if (g < DEPTH - 1) begin : g_nx
      assign nx_rank[g] = q_rank[g+1];
      assign nx_bank[g] = q_bank[g+1];
      assign nx_row[g]  = q_row[g+1];
    end else begin : g_last
      assign nx_rank[g] = q_rank[g];
      assign nx_bank[g] = q_bank[g];
      assign nx_row[g]  = q_row[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_rank[g] <= '0; q_bank[g] <= '0; q_row[g] <= '0;
      end else if (enq_acc && CNT_W'(g) == ins_pos) begin
        q_rank[g] <= enq_rank; q_bank[g] <= enq_bank; q_row[g] <= enq_row;
      end else if (remove && IDX_W'(g) >= win_idx) begin
        q_rank[g] <= nx_rank[g]; q_bank[g] <= nx_bank[g]; q_row[g] <= nx_row[g];
      end
    end
  end

  logic [NB_W-1:0] iss_bi;
  assign iss_bi = NB_W'(iss_rank) * NB_W'(BANKS) + NB_W'(iss_bank);

  for (genvar g = 0; g < NB; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        b_open[g] <= 1'b0; b_row[g] <= '0; b_at[g] <= '0; b_cc[g] <= '0;
      end else if (iss_cmd != 2'd0 && iss_bi == NB_W'(g)) begin
        b_at[g] <= iss_col_at;
        case (iss_cmd)
          CMD_ACT: begin b_open[g] <= 1'b1; b_row[g] <= iss_row; b_cc[g] <= '0; end
          CMD_COL: begin
            if (b_cc[g] == CC_W'(MAX_COL - 1)) begin
              b_open[g] <= 1'b0; b_cc[g] <= '0;
            end else begin
              b_cc[g] <= b_cc[g] + CC_W'(1);
            end
          end
          CMD_PRE: begin b_open[g] <= 1'b0; b_cc[g] <= '0; end
          default: ;
        endcase
      end
    end

    p_colcnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      b_cc[g] < CC_W'(MAX_COL));
    p_act_opens_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_cmd == CMD_ACT && iss_bi == NB_W'(g)) |=> b_open[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_found <= 1'b0; sel_idx <= '0; sel_rank <= '0; sel_bank <= '0; sel_row <= '0;
    end else begin
      sel_found <= remove;
      if (sel_strobe) begin
        sel_idx  <= win_idx;
        sel_rank <= q_rank[win_idx];
        sel_bank <= q_bank[win_idx];
        sel_row  <= q_row[win_idx];
      end
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && cnt == CNT_W'(DEPTH) && !remove) |=> cnt == CNT_W'(DEPTH));
  p_found_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_found |-> $past(sel_strobe));
  p_idx_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_found |-> CNT_W'(sel_idx) < $past(cnt));
  p_remove_shrinks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (remove && !enq_valid) |=> cnt == $past(cnt) - CNT_W'(1));
  p_nofound_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_strobe && !win_any && !enq_valid) |=> $stable(cnt) && !sel_found);
endmodule

// File: tb/test_rowhit_sched.sv
module test_rowhit_sched;
  localparam int DEPTH = 4, RANKS = 2, BANKS = 2, ROW_W = 3, CYC_W = 6;
  localparam int CAS = 3, TURN = 2, MAXC = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, enq_valid, dir_turn, sel_strobe;
  logic [0:0] enq_rank, enq_bank, iss_rank, iss_bank, sel_rank, sel_bank;
  logic [ROW_W-1:0] enq_row, iss_row, sel_row;
  logic [1:0] rank_avail, iss_cmd, sel_idx;
  logic [CYC_W-1:0] cur_cycle, bus_busy_until, iss_col_at;
  logic sel_found;
  logic [2:0] q_count;

  rowhit_sched #(.DEPTH(DEPTH), .RANKS(RANKS), .BANKS(BANKS), .ROW_W(ROW_W), .CYC_W(CYC_W),
                 .CAS_LAT(CAS), .TURN_LAT(TURN), .MAX_COL(MAXC)) i_rowhit_sched (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_rank(enq_rank), .enq_bank(enq_bank),
    .enq_row(enq_row), .rank_avail(rank_avail), .cur_cycle(cur_cycle),
    .bus_busy_until(bus_busy_until), .dir_turn(dir_turn), .sel_strobe(sel_strobe),
    .iss_cmd(iss_cmd), .iss_rank(iss_rank), .iss_bank(iss_bank), .iss_row(iss_row),
    .iss_col_at(iss_col_at), .sel_found(sel_found), .sel_idx(sel_idx), .sel_rank(sel_rank),
    .sel_bank(sel_bank), .sel_row(sel_row), .q_count(q_count));

  int n_chk = 0, n_fail = 0;
  int m_qr[DEPTH], m_qb[DEPTH], m_qw[DEPTH], m_cnt;
  int m_open[4], m_row[4], m_at[4], m_cc[4];
  logic [31:0] seed = 32'h1357_9bdf;

  task automatic rnd(input int m, output int v);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    v = int'(seed % 32'(m));
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; enq_valid = 0; sel_strobe = 0; iss_cmd = 0; dir_turn = 0;
    enq_rank = 0; enq_bank = 0; enq_row = 0; iss_rank = 0; iss_bank = 0; iss_row = 0;
    iss_col_at = 0; rank_avail = 2'b11; cur_cycle = 0; bus_busy_until = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_cnt = 0;
    for (int k = 0; k < 4; k++) begin m_open[k] = 0; m_row[k] = 0; m_at[k] = 0; m_cc[k] = 0; end
  endtask

  task automatic issue(input int cmd, input int r, input int b, input int row, input int at);
    int bi;
    iss_cmd = 2'(cmd); iss_rank = 1'(r); iss_bank = 1'(b); iss_row = 3'(row); iss_col_at = 6'(at);
    @(negedge clk);
    iss_cmd = 0;
    bi = r * BANKS + b;
    m_at[bi] = at;
    if (cmd == 1) begin m_open[bi] = 1; m_row[bi] = row; m_cc[bi] = 0; end
    else if (cmd == 3) begin m_open[bi] = 0; m_cc[bi] = 0; end
    else if (cmd == 2) begin
      m_cc[bi]++;
      if (m_cc[bi] == MAXC) begin m_open[bi] = 0; m_cc[bi] = 0; end
    end
  endtask

  task automatic enq(input int r, input int b, input int row);
    enq_valid = 1; enq_rank = 1'(r); enq_bank = 1'(b); enq_row = 3'(row);
    @(negedge clk);
    enq_valid = 0;
    if (m_cnt < DEPTH) begin
      m_qr[m_cnt] = r; m_qb[m_cnt] = b; m_qw[m_cnt] = row; m_cnt++;
    end
  endtask

  task automatic pick(output int cls, output int idx);
    int t, minc, bi;
    bit hit, rdy;
    int is_, ih, ip;
    is_ = -1; ih = -1; ip = -1;
    t = int'(bus_busy_until) + (dir_turn ? TURN : 0);
    minc = (t - CAS > int'(cur_cycle)) ? t - CAS : int'(cur_cycle);
    for (int k = 0; k < m_cnt; k++) begin
      bi = m_qr[k] * BANKS + m_qb[k];
      hit = m_open[bi] != 0 && m_row[bi] == m_qw[k];
      rdy = m_at[bi] <= minc;
      if (rank_avail[m_qr[k]]) begin
        if (hit && rdy && is_ < 0) is_ = k;
        if (!hit && rdy && ih < 0) ih = k;
        if (hit && !rdy && ip < 0) ip = k;
      end
    end
    if (is_ >= 0) begin cls = 1; idx = is_; end
    else if (ih >= 0) begin cls = 2; idx = ih; end
    else if (ip >= 0) begin cls = 3; idx = ip; end
    else begin cls = 0; idx = 0; end
  endtask

  task automatic sel_check(output int cls, output int got_idx);
    int idx;
    string tag;
    pick(cls, idx);
    sel_strobe = 1;
    @(negedge clk);
    sel_strobe = 0;
    got_idx = int'(sel_idx);
    tag = (cls == 1) ? "R5" : (cls == 2) ? "R6" : (cls == 3) ? "R7" : "R8";
    chk(tag, int'(sel_found), cls != 0 ? 1 : 0);
    if (cls != 0) begin
      chk(tag, int'(sel_idx), idx);
      chk("R9", int'(sel_rank), m_qr[idx]);
      chk("R9", int'(sel_bank), m_qb[idx]);
      chk("R9", int'(sel_row), m_qw[idx]);
      for (int k = idx; k < m_cnt - 1; k++) begin
        m_qr[k] = m_qr[k+1]; m_qb[k] = m_qb[k+1]; m_qw[k] = m_qw[k+1];
      end
      m_cnt--;
      chk("R9", int'(q_count), m_cnt);
    end else begin
      chk("R8", int'(q_count), m_cnt);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int cls, gi, v, n, op, nc;
    do_reset();
    chk("R1", int'(q_count), 0);
    chk("R1", int'(sel_found), 0);
    sel_check(cls, gi);

    // R3: threshold without and with turnaround
    for (int sw = 0; sw < 2; sw++) begin
      do_reset();
      issue(1, 0, 0, 1, 10);
      enq(0, 1, 5);
      enq(0, 0, 1);
      cur_cycle = 0; bus_busy_until = 12; dir_turn = 1'(sw);
      sel_check(cls, gi);
      chk("R3", gi, sw == 0 ? 0 : 1);
    end

    // R4: masked rank
    do_reset();
    issue(1, 0, 0, 1, 0);
    enq(0, 1, 5);
    enq(0, 0, 1);
    rank_avail = 2'b10;
    sel_check(cls, gi);
    chk("R4", int'(sel_found), 0);
    enq(1, 0, 2);
    sel_check(cls, gi);
    chk("R4", gi, 2);

    // R10: row forced closed on the MAX_COL-th column access
    do_reset();
    issue(1, 1, 1, 3, 0);
    issue(2, 1, 1, 0, 0);
    issue(2, 1, 1, 0, 0);
    enq(0, 0, 2);
    enq(1, 1, 3);
    cur_cycle = 5;
    sel_check(cls, gi);
    chk("R10", gi, 1);
    issue(2, 1, 1, 0, 0);
    enq(1, 1, 3);
    sel_check(cls, gi);
    chk("R10", gi, 0);

    for (int trial = 0; trial < 400; trial++) begin
      do_reset();
      if (trial % 50 == 0) chk("R1", int'(q_count), 0);
      for (int bk = 0; bk < 4; bk++) begin
        rnd(3, op);
        if (op != 0) begin
          rnd(4, v); rnd(20, n);
          issue(1, bk / 2, bk % 2, v, n);
          if (op == 2) begin rnd(20, n); issue(3, bk / 2, bk % 2, 0, n); end
          else begin
            rnd(4, nc);
            for (int c = 0; c < nc; c++) begin rnd(20, n); issue(2, bk / 2, bk % 2, 0, n); end
          end
        end
      end
      rnd(20, v); cur_cycle = 6'(v);
      rnd(30, v); bus_busy_until = 6'(v);
      rnd(2, v); dir_turn = 1'(v);
      rnd(4, v); rank_avail = 2'(v);
      rnd(6, n);
      for (int e = 0; e < n; e++) begin
        int r, b, w;
        rnd(2, r); rnd(2, b); rnd(4, w);
        enq(r, b, w);
      end
      chk("R2", int'(q_count), n < DEPTH ? n : DEPTH);
      for (int s = 0; s < 5; s++) begin
        sel_check(cls, gi);
        if (cls == 0) break;
      end
    end
    finish_run();
  end
endmodule